// File: doc/BRIEF.md
# BCD Real-Time Clock Calendar

This block keeps the time of day and the calendar as packed BCD bytes. It is driven from a single-cycle enable that pulses at 32.768 kHz; every higher unit of time is derived from that enable. A fractional divider turns the 32768 enables of each second into exactly one hundred hundredth-of-a-second steps. A ripple of BCD field counters then carries upward through seconds, minutes, 24-hour hours, a day-of-week counter, the date, the month and a two-digit year. The date wraps at the length of the current month, with February stretched to 29 days whenever the year value is a multiple of four. A single century bit flips each time the year passes from 99 to 00.

Software or a host controller sets the time through a simple byte write port that loads one field per cycle. Illegal values are cleaned up on the way in. Any write restarts the sub-second divider, so the next hundredth step begins from a clean boundary. The eight time bytes are always visible on dedicated outputs, and a one-cycle pulse marks each advance of the seconds byte. There is no stream interface, so there is no back-pressure: the write port has no ready signal, and every cycle with the write enable high is taken on that clock edge.

Top module: `rtc_bcd_calendar`

## Requirements
- R1: While reset is asserted and on release, the outputs read hundredths 00, seconds 00, minutes 00, hours 00, weekday 01, date 01, month byte 01 (century bit 0) and year 00, with the seconds pulse low.
- R2: Counting from the last write or from reset, the k-th hundredth step happens on the first enable n with n*100 >= k*32768. The first step therefore comes on enable 328, and exactly 100 steps occur per 32768 enables.
- R3: Every byte holds two BCD digits, each 0 to 9 (tens digit in bits 7:4). Hundredths wrap 99 to 00 and carry into seconds, seconds wrap 59 to 00 into minutes, and minutes wrap 59 to 00 into hours.
- R4: Hours count 00 to 23 in 24-hour form. The wrap from 23 to 00 advances the weekday and the date in the same cycle.
- R5: The weekday byte counts 01 to 07 and wraps back to 01.
- R6: The date wraps to 01 after 30 in months 04, 06, 09 and 11, after 31 in the other months, and in month 02 after 29 when the year is a multiple of four and after 28 otherwise. Each date wrap advances the month, and the month wraps 12 to 01 and advances the year.
- R7: The year wrap from 99 to 00 toggles the century bit, which is bit 7 of the month byte.
- R8: The seconds pulse is high for exactly the one cycle in which a newly advanced seconds value first appears, and never otherwise.
- R9: A write with wr_addr 0 to 7 loads hundredths, seconds, minutes, hours, weekday, date, month byte or year, visible after that edge. A tick enable in the same cycle is ignored, and the write restarts the R2 count from zero.
- R10: A written value with a digit above 9 or outside the field's legal range (hundredths 00-99, seconds/minutes 00-59, hours 00-23, weekday 01-07, date 01-31, month 01-12, year 00-99) loads that field's R1 value instead. On a month write, bit 7 always sets the century bit and is excluded from the month check.
- R11: In cycles with the tick enable and the write enable both low, no output changes and the sub-second count holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | One-cycle enable at 32.768 kHz |
| wr_en | input | 1 | Field write strobe |
| wr_addr | input | 3 | Field select for the write |
| wr_data | input | 8 | BCD value to write |
| hsec_o | output | 8 | Hundredths of a second, BCD |
| sec_o | output | 8 | Seconds, BCD |
| min_o | output | 8 | Minutes, BCD |
| hour_o | output | 8 | Hours 00-23, BCD |
| dow_o | output | 8 | Weekday 01-07 |
| date_o | output | 8 | Date 01-31, BCD |
| month_o | output | 8 | Bit 7 century, bits 6:0 month 01-12 BCD |
| year_o | output | 8 | Year 00-99, BCD |
| sec_pulse_o | output | 1 | One-cycle pulse per seconds advance |

## Verification
The embedded properties assume that writes only ever place a date that is legal for the month and year already held. They also assume that the 32.768 kHz enable is a plain level sampled each clock, so back-to-back enables are valid. The bench therefore loads states drawn from a model that only produces real calendar dates. It drives illegal bytes only in the directed clean-up checks, and those checks never write a date past the current month's length. Random starting times are biased toward each field's maximum, so that long carry chains, month ends and leap Februaries are crossed often within a few hundred enables.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  localparam int NUM_FIELDS = 8;

  typedef enum logic [2:0] {
    F_SUB  = 3'd0,
    F_SEC  = 3'd1,
    F_MIN  = 3'd2,
    F_HOUR = 3'd3,
    F_DOW  = 3'd4,
    F_DATE = 3'd5,
    F_MON  = 3'd6,
    F_YEAR = 3'd7
  } field_e;

  // lowest legal value, also the reset value of each field
  function automatic logic [7:0] fld_min(input logic [2:0] idx);
    case (idx)
      F_DOW, F_DATE, F_MON: return 8'h01;
      default:              return 8'h00;
    endcase
  endfunction

  function automatic logic [7:0] fld_max(input logic [2:0] idx);
    case (idx)
      F_SUB:   return 8'h99;
      F_SEC:   return 8'h59;
      F_MIN:   return 8'h59;
      F_HOUR:  return 8'h23;
      F_DOW:   return 8'h07;
      F_DATE:  return 8'h31;
      F_MON:   return 8'h12;
      default: return 8'h99;
    endcase
  endfunction

  function automatic logic digits_ok(input logic [7:0] v);
    return (v[3:0] <= 4'd9) && (v[7:4] <= 4'd9);
  endfunction

  // last date of the month; leap when the binary year is a multiple of four
  function automatic logic [7:0] month_days(input logic [7:0] mon, input logic [7:0] yr);
    logic [6:0] ybin;
    ybin = ({3'b000, yr[7:4]} * 7'd10) + {3'b000, yr[3:0]};
    case (mon)
      8'h02:                      return (ybin[1:0] == 2'b00) ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
      default:                    return 8'h31;
    endcase
  endfunction
endpackage

// File: rtl/rtc_subsec_div.sv
module rtc_subsec_div #(
  parameter int TICK_HZ = 32768,
  parameter int SUB_HZ  = 100
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_i,
  input  logic clr_i,
  output logic stb_o
);
  localparam int AW     = $clog2(TICK_HZ + SUB_HZ);
  localparam int GAP_LO = TICK_HZ / SUB_HZ;
  localparam int GAP_HI = (TICK_HZ + SUB_HZ - 1) / SUB_HZ;
  localparam logic [AW-1:0] STEP  = AW'(SUB_HZ);
  localparam logic [AW-1:0] LIMIT = AW'(TICK_HZ);

  logic [AW-1:0] acc_q;
  logic [AW-1:0] sum;

  // phase accumulator: add SUB_HZ per tick, emit a step on each overflow of TICK_HZ
  assign sum   = acc_q + STEP;
  assign stb_o = tick_i && !clr_i && (sum >= LIMIT);

  always_ff @(posedge clk) begin
    if (!rst_n || clr_i) acc_q <= '0;
    else if (tick_i)     acc_q <= stb_o ? (sum - LIMIT) : sum;
  end

  // spacing monitor: ticks since the last step or restart
  logic [AW-1:0] gap_q;
  always_ff @(posedge clk) begin
    if (!rst_n || clr_i || stb_o) gap_q <= '0;
    else if (tick_i)              gap_q <= gap_q + 1'b1;
  end

  AST_STEP_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
    stb_o |-> ((int'(gap_q) + 1 == GAP_LO) || (int'(gap_q) + 1 == GAP_HI))); // R2
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_i && !clr_i) |=> (acc_q == $past(acc_q))); // R11
endmodule

// File: rtl/rtc_bcd_field.sv
module rtc_bcd_field #(
  parameter logic [7:0] RST_VAL = 8'h00
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       inc_i,
  input  logic       wr_i,
  input  logic [7:0] wr_val_i,
  input  logic [7:0] min_i,
  input  logic [7:0] max_i,
  output logic [7:0] val_o,
  output logic       wrap_o
);
  logic [7:0] val_q;
  logic [7:0] nxt;

  assign val_o  = val_q;
  assign wrap_o = inc_i && (val_q >= max_i);

  always_comb begin
    nxt = val_q;
    if (wr_i)                   nxt = wr_val_i;
    else if (inc_i) begin
      if (val_q >= max_i)       nxt = min_i;
      else if (val_q[3:0] == 4'd9) nxt = {val_q[7:4] + 4'd1, 4'h0};
      else                      nxt = val_q + 8'd1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) val_q <= RST_VAL;
    else        val_q <= nxt;
  end

  AST_DIGITS_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    (val_q[3:0] <= 4'd9) && (val_q[7:4] <= 4'd9)); // R3
endmodule

// File: rtl/rtc_bcd_calendar.sv
module rtc_bcd_calendar
  import rtc_pkg::*;
#(
  parameter int TICK_HZ = 32768,
  parameter int SUB_HZ  = 100
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_en,
  input  logic       wr_en,
  input  logic [2:0] wr_addr,
  input  logic [7:0] wr_data,
  output logic [7:0] hsec_o,
  output logic [7:0] sec_o,
  output logic [7:0] min_o,
  output logic [7:0] hour_o,
  output logic [7:0] dow_o,
  output logic [7:0] date_o,
  output logic [7:0] month_o,
  output logic [7:0] year_o,
  output logic       sec_pulse_o
);
  logic [7:0]            val  [NUM_FIELDS];
  logic [7:0]            maxv [NUM_FIELDS];
  logic [NUM_FIELDS-1:0] inc, wrap, fwr;
  logic                  hs_stb, adv;
  logic [7:0]            wr_body, wr_val;
  logic                  wr_ok;
  logic                  cent_q, pulse_q;

  // a write owns its cycle: the tick is dropped and the divider restarts
  assign adv = tick_en && !wr_en;

  rtc_subsec_div #(.TICK_HZ(TICK_HZ), .SUB_HZ(SUB_HZ)) u_div (
    .clk(clk), .rst_n(rst_n), .tick_i(adv), .clr_i(wr_en), .stb_o(hs_stb)
  );

  // carry ripple: year <- month <- date, weekday <- hour <- minute <- second <- hundredth
  assign inc = {wrap[F_MON], wrap[F_DATE], wrap[F_HOUR], wrap[F_HOUR],
                wrap[F_MIN], wrap[F_SEC], wrap[F_SUB], hs_stb};

  // write clean-up: bad digit or out-of-range value loads the reset value
  always_comb begin
    wr_body = wr_data;
    if (wr_addr == F_MON) wr_body[7] = 1'b0;
    wr_ok  = digits_ok(wr_body) && (wr_body >= fld_min(wr_addr)) &&
             (wr_body <= fld_max(wr_addr));
    wr_val = wr_ok ? wr_body : fld_min(wr_addr);
  end

  for (genvar g = 0; g < NUM_FIELDS; g++) begin : g_fld
    localparam logic [7:0] RV = fld_min(3'(g));
    if (g == int'(F_DATE)) begin : g_dyn
      assign maxv[g] = month_days(val[F_MON], val[F_YEAR]);
    end else begin : g_fix
      assign maxv[g] = fld_max(3'(g));
    end
    assign fwr[g] = wr_en && (wr_addr == 3'(g));

    rtc_bcd_field #(.RST_VAL(RV)) u_fld (
      .clk(clk), .rst_n(rst_n), .inc_i(inc[g]), .wr_i(fwr[g]),
      .wr_val_i(wr_val), .min_i(RV), .max_i(maxv[g]),
      .val_o(val[g]), .wrap_o(wrap[g])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cent_q  <= 1'b0;
      pulse_q <= 1'b0;
    end else begin
      pulse_q <= wrap[F_SUB];
      if (fwr[F_MON])        cent_q <= wr_data[7];
      else if (wrap[F_YEAR]) cent_q <= ~cent_q;
    end
  end

  assign hsec_o      = val[F_SUB];
  assign sec_o       = val[F_SEC];
  assign min_o       = val[F_MIN];
  assign hour_o      = val[F_HOUR];
  assign dow_o       = val[F_DOW];
  assign date_o      = val[F_DATE];
  assign month_o     = {cent_q, val[F_MON][6:0]};
  assign year_o      = val[F_YEAR];
  assign sec_pulse_o = pulse_q;

  AST_HOUR_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    hour_o <= 8'h23); // R4
  AST_DOW_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (dow_o >= 8'h01) && (dow_o <= 8'h07)); // R5
  AST_CENTURY_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(year_o) == 8'h99 && year_o == 8'h00 && !$past(wr_en))
      |-> (month_o[7] != $past(month_o[7]))); // R7
  AST_PULSE_NEW_SECOND: assert property (@(posedge clk) disable iff (!rst_n)
    sec_pulse_o |-> (sec_o != $past(sec_o))); // R8
  AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_en && !wr_en) |=> ($stable(hsec_o) && $stable(sec_o) && $stable(date_o))); // R11
endmodule

// File: tb/rtc_bcd_calendar_tb.sv
module rtc_bcd_calendar_tb_top;
  logic       clk = 1'b0, rst_n = 1'b0, tick_en = 1'b0, wr_en = 1'b0;
  logic [2:0] wr_addr = 3'd0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] hsec_o, sec_o, min_o, hour_o, dow_o, date_o, month_o, year_o;
  logic       sec_pulse_o;

  int errors = 0, checks = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  rtc_bcd_calendar dut_i (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data),
    .hsec_o(hsec_o), .sec_o(sec_o), .min_o(min_o), .hour_o(hour_o),
    .dow_o(dow_o), .date_o(date_o), .month_o(month_o), .year_o(year_o),
    .sec_pulse_o(sec_pulse_o)
  );

  // binary reference model
  int m_sub, m_sec, m_min, m_hr, m_dow, m_date, m_mon, m_yr, m_cent, m_pulses;

  function automatic int mlen(int mon, int yr);
    if (mon == 2) return (yr % 4 == 0) ? 29 : 28;
    if (mon == 4 || mon == 6 || mon == 9 || mon == 11) return 30;
    return 31;
  endfunction

  function automatic logic [7:0] bcd(int v);
    return 8'(((v / 10) << 4) | (v % 10));
  endfunction

  function automatic int rnd(int lo, int hi);
    return lo + int'($urandom % 32'(hi - lo + 1));
  endfunction

  function automatic int edge_pick(int lo, int hi);
    return ($urandom % 2 == 0) ? hi : rnd(lo, hi);
  endfunction

  function automatic void model_step();
    m_sub++;
    if (m_sub < 100) return;
    m_sub = 0; m_sec++; m_pulses++;
    if (m_sec < 60) return;
    m_sec = 0; m_min++;
    if (m_min < 60) return;
    m_min = 0; m_hr++;
    if (m_hr < 24) return;
    m_hr = 0;
    m_dow = (m_dow == 7) ? 1 : m_dow + 1;
    if (m_date < mlen(m_mon, m_yr)) begin m_date++; return; end
    m_date = 1; m_mon++;
    if (m_mon <= 12) return;
    m_mon = 1; m_yr++;
    if (m_yr < 100) return;
    m_yr = 0; m_cent ^= 1;
  endfunction

  task automatic chk(string tag, string what, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%02h expected=%02h", tag, what, act, exp);
    end
  endtask

  task automatic chk_int(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic chk_all(string tag);
    chk(tag, "hsec", hsec_o, bcd(m_sub));
    chk(tag, "sec", sec_o, bcd(m_sec));
    chk(tag, "min", min_o, bcd(m_min));
    chk(tag, "hour", hour_o, bcd(m_hr));
    chk(tag, "dow", dow_o, bcd(m_dow));
    chk(tag, "date", date_o, bcd(m_date));
    chk(tag, "month", month_o, {m_cent[0], bcd(m_mon)[6:0]});
    chk(tag, "year", year_o, bcd(m_yr));
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d, input bit tk);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d; tick_en = tk;
    @(negedge clk);
    wr_en = 1'b0; tick_en = 1'b0;
  endtask

  task automatic load_model();
    wr(3'd7, bcd(m_yr), 1'b0);
    wr(3'd6, {m_cent[0], bcd(m_mon)[6:0]}, 1'b0);
    wr(3'd5, bcd(m_date), 1'b0);
    wr(3'd4, bcd(m_dow), 1'b0);
    wr(3'd3, bcd(m_hr), 1'b0);
    wr(3'd2, bcd(m_min), 1'b0);
    wr(3'd1, bcd(m_sec), 1'b0);
    wr(3'd0, bcd(m_sub), 1'b0);
  endtask

  task automatic ticks(input int n, output int p);
    p = 0;
    if (n == 0) return;
    @(negedge clk); tick_en = 1'b1;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (sec_pulse_o) p++;
    end
    tick_en = 1'b0;
  endtask

  // n enables right after a load; model advances floor(n*100/32768) hundredths
  task automatic run_check(string tag, int n);
    int p;
    ticks(n, p);
    m_pulses = 0;
    repeat ((n * 100) / 32768) model_step();
    chk_all(tag);
    chk_int(tag, "second pulses", p, m_pulses);
  endtask

  task automatic set_model(int su, int se, int mi, int hr, int dw, int dt, int mo, int yr, int ce);
    m_sub = su; m_sec = se; m_min = mi; m_hr = hr; m_dow = dw;
    m_date = dt; m_mon = mo; m_yr = yr; m_cent = ce;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog R2: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int p;
    void'($urandom(32'd20240611));
    repeat (4) @(negedge clk);
    // R1 reset state, during and after reset
    set_model(0, 0, 0, 0, 1, 1, 1, 0, 0);
    chk_all("R1");
    chk("R1", "pulse", {7'd0, sec_pulse_o}, 8'h00);
    rst_n = 1'b1;
    @(negedge clk);
    chk_all("R1");

    // R7 R3 R4 R5: full carry through the century
    set_model(99, 59, 59, 23, 7, 31, 12, 99, 0);
    load_model();
    run_check("R7", 328);

    // R4 hour carry without midnight
    set_model(99, 59, 59, 13, 3, 10, 5, 40, 1);
    load_model();
    run_check("R4", 328);

    // R6 month lengths and leap February
    set_model(99, 59, 59, 23, 2, 28, 2, 23, 0); load_model(); run_check("R6", 328);
    set_model(99, 59, 59, 23, 2, 28, 2, 24, 0); load_model(); run_check("R6", 328);
    set_model(99, 59, 59, 23, 2, 29, 2, 24, 0); load_model(); run_check("R6", 328);
    set_model(99, 59, 59, 23, 5, 30, 4, 10, 0); load_model(); run_check("R6", 328);
    set_model(99, 59, 59, 23, 5, 31, 1, 10, 0); load_model(); run_check("R6", 328);
    set_model(99, 59, 59, 23, 6, 30, 11, 0, 0); load_model(); run_check("R6", 328);

    // R2: first step on enable 328, 100 steps per 32768 enables
    set_model(0, 0, 0, 0, 1, 1, 1, 0, 0);
    load_model();
    run_check("R2", 327);
    ticks(1, p); model_step();
    chk_all("R2");
    set_model(0, 10, 0, 0, 1, 1, 1, 0, 0);
    load_model();
    run_check("R2", 32767);
    ticks(1, p); m_pulses = 0; model_step();
    chk_all("R2");
    chk_int("R8", "pulse at full second", p, 1);

    // R9: tick in a write cycle is dropped and the divider restarts
    set_model(20, 5, 6, 7, 2, 3, 4, 5, 0);
    load_model();
    ticks(200, p);
    wr(3'd0, 8'h50, 1'b1);
    m_sub = 50;
    chk_all("R9");
    run_check("R9", 327);
    ticks(1, p); model_step();
    chk_all("R9");

    // R11: idle cycles hold the partial divider count
    set_model(10, 0, 0, 0, 1, 1, 1, 0, 0);
    load_model();
    ticks(200, p);
    repeat (500) @(negedge clk);
    chk_all("R11");
    ticks(127, p);
    chk_all("R11");
    ticks(1, p); model_step();
    chk_all("R11");

    // R10 write clean-up
    set_model(0, 0, 0, 0, 1, 1, 1, 0, 0);
    load_model();
    wr(3'd3, 8'h24, 1'b0); chk("R10", "hour 24", hour_o, 8'h00);
    wr(3'd3, 8'h17, 1'b0); chk("R10", "hour 17", hour_o, 8'h17);
    wr(3'd3, 8'h1A, 1'b0); chk("R10", "hour 1A", hour_o, 8'h00);
    wr(3'd1, 8'h60, 1'b0); chk("R10", "sec 60", sec_o, 8'h00);
    wr(3'd4, 8'h00, 1'b0); chk("R10", "dow 00", dow_o, 8'h01);
    wr(3'd4, 8'h08, 1'b0); chk("R10", "dow 08", dow_o, 8'h01);
    wr(3'd5, 8'h32, 1'b0); chk("R10", "date 32", date_o, 8'h01);
    wr(3'd6, 8'h93, 1'b0); chk("R10", "month 93", month_o, 8'h81);
    wr(3'd6, 8'h8C, 1'b0); chk("R10", "month 8C", month_o, 8'h81);
    wr(3'd7, 8'hA0, 1'b0); chk("R10", "year A0", year_o, 8'h00);
    wr(3'd0, 8'h9F, 1'b0); chk("R10", "hsec 9F", hsec_o, 8'h00);

    // random starts biased to field maxima (R3 R6 R8)
    for (int t = 0; t < 24; t++) begin
      int n;
      m_yr = edge_pick(0, 99); m_mon = edge_pick(1, 12);
      m_date = edge_pick(1, mlen(m_mon, m_yr));
      m_dow = edge_pick(1, 7); m_hr = edge_pick(0, 23);
      m_min = edge_pick(0, 59); m_sec = edge_pick(0, 59);
      m_sub = rnd(90, 99); m_cent = rnd(0, 1);
      load_model();
      n = 328 * rnd(1, 3) + rnd(0, 60);
      run_check("R3", n);
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule